// File: doc/BRIEF.md
# Cache Line Clean Controller

This block sits beside a small direct-mapped write-back data cache and performs a "clean" on one byte address. The cache line that holds the address is copied out to memory only when it carries modified data. Afterwards the line normally stays resident with its dirty flag cleared, so a later access still hits. A configuration input may instead drop the line after the clean. Either result is legal for software that only needs the data to reach memory.

Stores reach the cache through a small in-order store buffer. A clean waits until no buffered store to its line remains, so every store accepted no later than the clean is part of the data written out. A fence input is acknowledged only when no clean is active or being requested. Cleans are handled one at a time. A lookup port lets the surrounding logic read the state of any line without side effects.

Top module: `ccc_clean_ctrl`

## Requirements
- R1: After reset every line is invalid, `busy`, `clean_done` and `mem_valid` are low, and `st_ready` is high.
- R2: An accepted store writes its 32-bit word (word select = address bits 3:2, bits 1:0 ignored) into line index bits 6:4 and sets the line's tag (bits 15:7), valid flag and dirty flag. The other words of that line keep their old contents, even when the tag changes.
- R3: A clean of a resident dirty line writes all four words to memory in ascending order. Word k goes to the line base plus 4*k, whatever byte offset the request carried.
- R4: A clean of a line that is absent, or resident but not dirty, issues no memory write.
- R5: With `drop_line` low, a cleaned line that was resident stays valid and not dirty, and its data is unchanged.
- R6: With `drop_line` high at request time, a cleaned line that was resident is invalid afterwards.
- R7: A store accepted in the same cycle as a clean, or earlier, to the same line is merged before the lookup, and so it appears in the write-back.
- R8: `fence_ack` is high only while `fence_req` is high, no clean is active and `clean_valid` is low.
- R9: `clean_done` is a one-cycle pulse. It comes one cycle after the final write beat, or three cycles after acceptance when no write is needed. Each matching store still buffered at acceptance adds one cycle.
- R10: `clean_ready` is low while a clean is active. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 16 | Store byte address |
| st_data | input | 32 | Store word |
| st_ready | output | 1 | Store buffer has room |
| clean_valid | input | 1 | Clean request |
| clean_addr | input | 16 | Byte address whose line is cleaned |
| drop_line | input | 1 | Invalidate the line instead of keeping it |
| clean_ready | output | 1 | A clean request is accepted this cycle |
| busy | output | 1 | A clean is in progress |
| clean_done | output | 1 | Completion pulse |
| fence_req | input | 1 | Fence waiting for earlier cleans |
| fence_ack | output | 1 | Fence may proceed |
| mem_valid | output | 1 | Write-back beat valid |
| mem_addr | output | 16 | Write-back word address |
| mem_data | output | 32 | Write-back word |
| mem_ready | input | 1 | Memory takes the beat |
| probe_addr | input | 16 | Lookup address |
| probe_hit | output | 1 | Lookup line resident with matching tag |
| probe_dirty | output | 1 | Lookup line is dirty |
| probe_data | output | 32 | Word selected by the lookup address |

## Verification
The request is driven on a falling edge and taken at the next rising edge. Counting falling edges from there, the bench expects `clean_done` on the third for a clean with no write. When `mem_ready` is held high, a dirty line adds four beats, and a same-line store issued together with the clean adds one more cycle. Write beats are recorded on the falling edge before the rising edge that takes them, which is when both `mem_valid` and `mem_ready` are high. The bench compares the latency counts exactly only when `mem_ready` is held high. Line state is read through the lookup port one settle step after its address is set, once the completion pulse has been seen.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int ADDR_W     = 16;
  localparam int WORD_W     = 32;
  localparam int LINE_BYTES = 16;
  localparam int NLINES     = 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NLINES);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W     = ADDR_W - OFF_W;
  localparam int WPL        = LINE_BYTES * 8 / WORD_W;
  localparam int WSEL_W     = $clog2(WPL);
  localparam int BYTE_W     = OFF_W - WSEL_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WSEL_W-1:0] wsel_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic [1:0] {CS_IDLE, CS_DRAIN, CS_LOOK, CS_WB} cstate_t;

  function automatic line_t line_of(addr_t a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic idx_t idx_of(addr_t a);
    return a[OFF_W+IDX_W-1:OFF_W];
  endfunction
  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1:OFF_W+IDX_W];
  endfunction
  function automatic wsel_t wsel_of(addr_t a);
    return a[OFF_W-1:BYTE_W];
  endfunction
  function automatic addr_t beat_addr(tag_t t, idx_t i, wsel_t w);
    return {t, i, w, {BYTE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ccc_store_buf.sv
module ccc_store_buf
  import ccc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  addr_t push_addr,
  input  word_t push_data,
  output logic  full,
  input  logic  pop,
  output logic  empty,
  output addr_t head_addr,
  output word_t head_data,
  input  line_t look_line,
  output logic  line_pending
);
  localparam int PW = $clog2(DEPTH);

  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] hit_v;
  addr_t            ent_a [DEPTH];
  word_t            ent_d [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = &occ;
  assign empty   = ~|occ;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      wp  <= '0;
      rp  <= '0;
    end else begin
      if (do_push) begin
        occ[wp] <= 1'b1;
        wp      <= wp + 1'b1;
      end
      if (do_pop) begin
        occ[rp] <= 1'b0;
        rp      <= rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      ent_a[wp] <= push_addr;
      ent_d[wp] <= push_data;
    end
  end

  assign head_addr = ent_a[rp];
  assign head_data = ent_d[rp];

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_v[g] = occ[g] && (line_of(ent_a[g]) == look_line);
  end
  assign line_pending = |hit_v;
endmodule

// File: rtl/ccc_line_array.sv
module ccc_line_array
  import ccc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  input  logic  upd_en,
  input  logic  upd_drop,
  input  idx_t  upd_idx,
  input  idx_t  a_idx,
  input  wsel_t a_wsel,
  output logic  a_valid,
  output logic  a_dirty,
  output tag_t  a_tag,
  output word_t a_word,
  input  idx_t  b_idx,
  input  wsel_t b_wsel,
  output logic  b_valid,
  output logic  b_dirty,
  output tag_t  b_tag,
  output word_t b_word
);
  logic [NLINES-1:0] vld, dty;
  tag_t              tg  [NLINES];
  word_t             dat [NLINES][WPL];
  idx_t              wi;
  wsel_t             ws;

  assign wi = idx_of(wr_addr);
  assign ws = wsel_of(wr_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      dty <= '0;
      for (int i = 0; i < NLINES; i++) begin
        tg[i] <= '0;
        for (int j = 0; j < WPL; j++) dat[i][j] <= '0;
      end
    end else begin
      if (wr_en) begin
        tg[wi]      <= tag_of(wr_addr);
        vld[wi]     <= 1'b1;
        dty[wi]     <= 1'b1;
        dat[wi][ws] <= wr_data;
      end
      if (upd_en) begin
        dty[upd_idx] <= 1'b0;
        if (upd_drop) vld[upd_idx] <= 1'b0;
      end
    end
  end

  assign a_valid = vld[a_idx];
  assign a_dirty = dty[a_idx];
  assign a_tag   = tg[a_idx];
  assign a_word  = dat[a_idx][a_wsel];
  assign b_valid = vld[b_idx];
  assign b_dirty = dty[b_idx];
  assign b_tag   = tg[b_idx];
  assign b_word  = dat[b_idx][b_wsel];
endmodule

// File: rtl/ccc_clean_fsm.sv
module ccc_clean_fsm
  import ccc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  addr_t req_addr,
  input  logic  req_drop,
  input  logic  sb_line_pending,
  output line_t tgt_line,
  input  logic  a_valid,
  input  logic  a_dirty,
  input  tag_t  a_tag,
  input  word_t a_word,
  output idx_t  a_idx,
  output wsel_t a_wsel,
  output logic  mem_valid,
  output addr_t mem_addr,
  output word_t mem_data,
  input  logic  mem_ready,
  output logic  upd_en,
  output logic  upd_drop,
  output logic  done,
  output logic  busy,
  output logic  drain_ok
);
  cstate_t st;
  line_t   lat;
  logic    drop_q, done_q;
  wsel_t   beat;
  tag_t    t_tag;
  idx_t    t_idx;
  logic    hit, need_wb, last_beat;

  assign t_tag     = lat[LINE_W-1:IDX_W];
  assign t_idx     = lat[IDX_W-1:0];
  assign hit       = a_valid && (a_tag == t_tag);
  assign need_wb   = hit && a_dirty;
  assign last_beat = (beat == wsel_t'(WPL - 1));

  assign mem_valid = (st == CS_WB);
  assign mem_addr  = beat_addr(t_tag, t_idx, beat);
  assign mem_data  = a_word;
  assign a_idx     = t_idx;
  assign a_wsel    = beat;
  assign upd_en    = ((st == CS_LOOK) && hit && !a_dirty) ||
                     ((st == CS_WB) && mem_ready && last_beat);
  assign upd_drop  = drop_q;
  assign busy      = (st != CS_IDLE);
  assign drain_ok  = (st == CS_IDLE) || (st == CS_DRAIN);
  assign done      = done_q;
  assign tgt_line  = lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= CS_IDLE;
      lat    <= '0;
      drop_q <= 1'b0;
      beat   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        CS_IDLE: if (req_valid) begin
          lat    <= line_of(req_addr);
          drop_q <= req_drop;
          st     <= CS_DRAIN;
        end
        CS_DRAIN: if (!sb_line_pending) st <= CS_LOOK;
        CS_LOOK: begin
          beat <= '0;
          if (need_wb) st <= CS_WB;
          else begin
            st     <= CS_IDLE;
            done_q <= 1'b1;
          end
        end
        default: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (last_beat) begin
            st     <= CS_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ccc_clean_ctrl.sv
module ccc_clean_ctrl
  import ccc_pkg::*;
#(
  parameter int SB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        st_valid,
  input  logic [15:0] st_addr,
  input  logic [31:0] st_data,
  output logic        st_ready,
  input  logic        clean_valid,
  input  logic [15:0] clean_addr,
  input  logic        drop_line,
  output logic        clean_ready,
  output logic        busy,
  output logic        clean_done,
  input  logic        fence_req,
  output logic        fence_ack,
  output logic        mem_valid,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_data,
  input  logic        mem_ready,
  input  logic [15:0] probe_addr,
  output logic        probe_hit,
  output logic        probe_dirty,
  output logic [31:0] probe_data
);
  logic  sb_full, sb_empty, sb_pending, drain_ok, drain;
  addr_t sb_addr;
  word_t sb_data;
  line_t tgt_line;
  logic  a_valid, a_dirty, b_valid, b_dirty;
  tag_t  a_tag, b_tag;
  word_t a_word;
  idx_t  a_idx;
  wsel_t a_wsel;
  logic  line_upd_en, line_upd_drop;

  assign st_ready    = !sb_full;
  assign drain       = drain_ok && !sb_empty;
  assign clean_ready = !busy;
  assign fence_ack   = fence_req && !busy && !clean_valid;

  ccc_store_buf #(.DEPTH(SB_DEPTH)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .push(st_valid), .push_addr(st_addr), .push_data(st_data), .full(sb_full),
    .pop(drain), .empty(sb_empty), .head_addr(sb_addr), .head_data(sb_data),
    .look_line(tgt_line), .line_pending(sb_pending)
  );

  ccc_line_array u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(drain), .wr_addr(sb_addr), .wr_data(sb_data),
    .upd_en(line_upd_en), .upd_drop(line_upd_drop), .upd_idx(a_idx),
    .a_idx(a_idx), .a_wsel(a_wsel), .a_valid(a_valid), .a_dirty(a_dirty),
    .a_tag(a_tag), .a_word(a_word),
    .b_idx(idx_of(probe_addr)), .b_wsel(wsel_of(probe_addr)), .b_valid(b_valid),
    .b_dirty(b_dirty), .b_tag(b_tag), .b_word(probe_data)
  );

  ccc_clean_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(clean_valid), .req_addr(clean_addr), .req_drop(drop_line),
    .sb_line_pending(sb_pending), .tgt_line(tgt_line),
    .a_valid(a_valid), .a_dirty(a_dirty), .a_tag(a_tag), .a_word(a_word),
    .a_idx(a_idx), .a_wsel(a_wsel),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .upd_en(line_upd_en), .upd_drop(line_upd_drop),
    .done(clean_done), .busy(busy), .drain_ok(drain_ok)
  );

  assign probe_hit   = b_valid && (b_tag == tag_of(probe_addr));
  assign probe_dirty = probe_hit && b_dirty;
endmodule

// File: rtl/ccc_clean_chk.sv
module ccc_clean_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        clean_done,
  input logic        fence_ack,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [15:0] mem_addr,
  input logic [31:0] mem_data,
  input logic        line_upd_en
);
  assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clean_done |-> !busy);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clean_done |=> !clean_done);
  assert_update_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_upd_en |=> clean_done);
  assert_fence_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ack |-> !busy);
  assert_beat_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);
  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));
endmodule

bind ccc_clean_ctrl ccc_clean_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .clean_done(clean_done),
  .fence_ack(fence_ack), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .line_upd_en(line_upd_en)
);

// File: tb/tb_ccc_clean_ctrl.sv
module tb_ccc_clean_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, st_valid, st_ready, clean_valid, drop_line, clean_ready;
  logic        busy, clean_done, fence_req, fence_ack, mem_valid, mem_ready;
  logic        probe_hit, probe_dirty;
  logic [15:0] st_addr, clean_addr, mem_addr, probe_addr;
  logic [31:0] st_data, mem_data, probe_data;

  ccc_clean_ctrl dut (.*);

  int errs = 0, checks = 0;
  bit finished = 0;

  bit          mv [8];
  bit          md [8];
  int          mtag [8];
  logic [31:0] mdat [8][4];

  function automatic int f_idx(logic [15:0] a); return int'((a >> 4) & 16'h7); endfunction
  function automatic int f_tag(logic [15:0] a); return int'(a >> 7); endfunction
  function automatic int f_w(logic [15:0] a);   return int'((a >> 2) & 16'h3); endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_store(input logic [15:0] a, input logic [31:0] d);
    mtag[f_idx(a)] = f_tag(a);
    mv[f_idx(a)] = 1;
    md[f_idx(a)] = 1;
    mdat[f_idx(a)][f_w(a)] = d;
  endtask

  task automatic probe_chk(input logic [15:0] a, input string req);
    bit eh;
    probe_addr = a;
    #1;
    eh = mv[f_idx(a)] && (mtag[f_idx(a)] == f_tag(a));
    chk(probe_hit == eh, {req, " hit"}, 32'(probe_hit), 32'(eh));
    if (eh) begin
      chk(probe_dirty == md[f_idx(a)], {req, " dirty"}, 32'(probe_dirty), 32'(md[f_idx(a)]));
      chk(probe_data == mdat[f_idx(a)][f_w(a)], {req, " data"}, probe_data, mdat[f_idx(a)][f_w(a)]);
    end
  endtask

  task automatic do_store(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 0;
    model_store(a, d);
  endtask

  task automatic do_clean(input logic [15:0] a, input bit drop, input bit with_st,
                          input logic [15:0] sa, input logic [31:0] sd,
                          input bit all_ready, input bit fence);
    logic [15:0] ga [4];
    logic [31:0] gd [4];
    int ng = 0, lat = -1, idx, tg, same, exp_lat;
    bit hit, wb, ready_bad = 0, fence_bad = 0;
    if (with_st) model_store(sa, sd);
    same = (with_st && ((sa >> 4) == (a >> 4))) ? 1 : 0;
    idx = f_idx(a); tg = f_tag(a);
    hit = mv[idx] && (mtag[idx] == tg);
    wb = hit && md[idx];
    @(negedge clk);
    clean_valid = 1; clean_addr = a; drop_line = drop; fence_req = fence;
    if (with_st) begin st_valid = 1; st_addr = sa; st_data = sd; end
    #1;
    chk(clean_ready == 1, "R10 ready when idle", 32'(clean_ready), 1);
    if (fence) chk(fence_ack == 0, "R8 ack with request", 32'(fence_ack), 0);
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      clean_valid = 0; st_valid = 0;
      mem_ready = all_ready ? 1'b1 : 1'($urandom % 2);
      #1;
      if (clean_done) begin lat = k; break; end
      if (clean_ready) ready_bad = 1;
      if (fence && fence_ack) fence_bad = 1;
      if (mem_valid && mem_ready) begin
        if (ng < 4) begin ga[ng] = mem_addr; gd[ng] = mem_data; end
        ng++;
      end
    end
    chk(lat > 0, "R9 done seen", 32'(lat), 1);
    chk(ng == (wb ? 4 : 0), wb ? "R3 beat count" : "R4 no write", 32'(ng), wb ? 4 : 0);
    if (wb && ng == 4)
      for (int k = 0; k < 4; k++) begin
        chk(ga[k] == 16'((tg << 7) | (idx << 4) | (k << 2)), "R3 beat address", 32'(ga[k]),
            32'((tg << 7) | (idx << 4) | (k << 2)));
        chk(gd[k] == mdat[idx][k], same ? "R7 merged data" : "R3 beat data", gd[k], mdat[idx][k]);
      end
    if (all_ready) begin
      exp_lat = 3 + same + (wb ? 4 : 0);
      chk(lat == exp_lat, "R9 latency", 32'(lat), 32'(exp_lat));
    end
    chk(!ready_bad, "R10 ready low while busy", 32'(ready_bad), 0);
    if (fence) begin
      chk(!fence_bad, "R8 ack during clean", 32'(fence_bad), 0);
      chk(fence_ack == 1, "R8 ack after done", 32'(fence_ack), 1);
    end
    fence_req = 0;
    if (hit) begin
      md[idx] = 0;
      if (drop) mv[idx] = 0;
    end
    probe_chk(a, drop ? "R6 after clean" : "R5 after clean");
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; clean_valid = 0; clean_addr = 0;
    drop_line = 0; fence_req = 0; mem_ready = 1; probe_addr = 0;
    for (int i = 0; i < 8; i++) begin
      mv[i] = 0; md[i] = 0; mtag[i] = 0;
      for (int w = 0; w < 4; w++) mdat[i][w] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(mem_valid == 0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(clean_done == 0, "R1 done", 32'(clean_done), 0);
    chk(st_ready == 1, "R1 st_ready", 32'(st_ready), 1);
    for (int i = 0; i < 8; i++) probe_chk(16'(i << 4), "R1 line invalid");
    rst_n = 1;

    do_clean(16'h0040, 0, 0, 0, 0, 1, 0);
    do_store(16'h0124, 32'hA1B2C3D4);
    do_store(16'h0128, 32'h0BADF00D);
    @(negedge clk);
    probe_chk(16'h0124, "R2 store");
    do_clean(16'h012B, 0, 0, 0, 0, 1, 0);
    do_clean(16'h0120, 0, 0, 0, 0, 1, 0);
    do_clean(16'h0120, 0, 1, 16'h012C, 32'h5EED5EED, 1, 0);
    do_clean(16'h0120, 0, 1, 16'h0300, 32'h12345678, 1, 0);
    do_store(16'h0200, 32'hCAFEF00D);
    do_clean(16'h0204, 1, 0, 0, 0, 1, 0);
    do_store(16'h0230, 32'h11112222);
    do_clean(16'h0230, 0, 0, 0, 0, 1, 0);
    do_clean(16'h0230, 1, 0, 0, 0, 1, 0);
    do_store(16'h0010, 32'h01010101);
    do_store(16'h0094, 32'h02020202);
    @(negedge clk);
    probe_chk(16'h0010, "R2 replaced tag");
    probe_chk(16'h0094, "R2 new tag");
    probe_chk(16'h0090, "R2 stale word");
    do_store(16'h0164, 32'hFEEDBEEF);
    do_clean(16'h0164, 0, 0, 0, 0, 0, 1);

    for (int it = 0; it < 400; it++) begin
      logic [15:0] a, sa;
      a = 16'($urandom % 512);
      sa = 16'($urandom % 512);
      if ($urandom % 10 < 6) do_store(a, $urandom);
      else do_clean(a, ($urandom % 4) == 0, ($urandom % 5) == 0, sa, $urandom,
                    ($urandom % 2) == 0, ($urandom % 3) == 0);
    end

    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++)
      if (mv[i]) for (int w = 0; w < 4; w++) probe_chk(16'((mtag[i] << 7) | (i << 4) | (w << 2)), "R2 final");
      else for (int t = 0; t < 4; t++) probe_chk(16'((t << 7) | (i << 4)), "R6 final");
    finished = 1;
    summary();
  end
endmodule